// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation words from memory, one 32-bit word at a time. A start pulse latches the virtual address, an access-is-write flag, the context table pointer and the context number. The walker then fetches the entry for that context. From there it descends through up to three levels of tables until it reaches a leaf entry. If the leaf sits at the first or second level, the walk stops early and the result is a large page.

Each fetched word carries a two-bit kind code. Bad kinds, a bus error on a read, and misplaced entries all end the walk with a fault code that records the level where it happened. When a leaf's referenced flag is clear, or a write finds its modified flag clear, the walker stores the updated word back to the place it was read from. It does this before it reports the result. The block takes one walk at a time.

Top module: `tablewalk_unit`

## Requirements
- R1: The first read of a walk goes to (context table pointer << 4) + (context number << 2).
- R2: An entry with kind 1 (table) at levels 0 to 2 sends the next read to ((entry with bits [1:0] cleared) << 4) + index×4. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R3: A leaf (kind 2) at level 1, 2 or 3 reports page size code 3 (16 MB), 2 (256 KB) or 1 (4 KB). The physical address is {entry[31:8] + unconsumed offset pages, VA[11:0]}. The offset pages are VA[23:12] at level 1, VA[17:12] at level 2 and none at level 3. The fault code is 0.
- R4: An entry of kind 0 (invalid) ends the walk with fault code (level << 8) | (1 << 2).
- R5: A reserved entry (kind 3), a read that returns the error flag, a table entry at level 3, or a leaf in the context table (level 0) ends the walk with fault code (level << 8) | (4 << 2).
- R6: Entry bit 5 is the referenced flag and bit 6 is the modified flag. A write-back happens if the leaf has bit 5 clear, or if the access is a write and bit 6 is clear. The write-back stores the leaf with bit 5 set, and with bit 6 also set on a write, to the leaf's own address. The reported leaf is this updated word.
- R7: A leaf whose flags need no change causes no memory write.
- R8: A start pulse while the walker is busy is ignored. The running walk finishes unchanged and no second walk follows.
- R9: Completion raises done_o for exactly one cycle. On a fault, the physical address, leaf and page size read 0. The results hold after done_o falls.
- R10: A memory request held without ready keeps its valid, address, write flag and data unchanged.
- R11: After reset the walker is idle, makes no request and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| va_i | input | VA_W | Virtual address to translate |
| wr_i | input | 1 | Access is a write |
| ctp_i | input | CTP_W | Context table pointer |
| ctx_i | input | CTX_W | Context number |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | PA_W | Request byte address |
| mem_req_we_o | output | 1 | Request is a write-back |
| mem_req_wdata_o | output | 32 | Write-back data |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response word |
| mem_rsp_err_i | input | 1 | Read response bus error |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | PA_W | Translated physical address |
| leaf_o | output | 32 | Leaf entry after flag update |
| page_size_o | output | 2 | 0 none, 1 4 KB, 2 256 KB, 3 16 MB |
| fault_o | output | FAULT_W | Fault code, 0 on success |

## Verification
The bound checker watches several rules on every cycle. The first request address must follow from the latched pointer and context. A stalled request must stay stable. The done pulse must last one cycle and carry a well-formed fault code, with zeroed results on a fault. Every write-back must carry the referenced flag. Other behaviour can only be shown by the bench's scenarios against a modelled memory: the later-level addresses, the early large-page exits and their physical addresses, the fault levels, whether a write-back happens and what data it stores, and ignoring a start during a walk.

// File: rtl/tablewalk_pkg.sv
package tablewalk_pkg;
   localparam int ENT_W   = 32;
   localparam int REF_BIT = 5;
   localparam int MOD_BIT = 6;
   localparam int PPN_LSB = 8;
   localparam int LVL_W   = 2;
   localparam int MAX_LVL = 3;

   typedef enum logic [1:0] {
      EK_INVALID = 2'd0,
      EK_TABLE   = 2'd1,
      EK_LEAF    = 2'd2,
      EK_RSVD    = 2'd3
   } ent_kind_e;

   typedef enum logic [1:0] {
      PS_NONE = 2'd0,
      PS_4K   = 2'd1,
      PS_256K = 2'd2,
      PS_16M  = 2'd3
   } pg_size_e;

   localparam logic [2:0] FT_INVALID = 3'd1;
   localparam logic [2:0] FT_XLATE   = 3'd4;

   typedef enum logic [1:0] {
      DC_DESCEND = 2'd0,
      DC_LEAF    = 2'd1,
      DC_FAULT   = 2'd2
   } dec_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2,
      ST_WBACK = 2'd3
   } walk_st_e;
endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
   import tablewalk_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 36,
   parameter int CTX_W   = 8,
   parameter int L1_BITS = 8,
   parameter int L2_BITS = 6,
   parameter int L3_BITS = 6
) (
   input  logic [LVL_W-1:0] level_i,
   input  logic [PA_W-1:0]  base_i,
   input  logic [CTX_W-1:0] ctx_i,
   input  logic [VA_W-1:0]  va_i,
   output logic [PA_W-1:0]  addr_o
);
   function automatic int lvl_bits(int l);
      case (l)
         1:       return L1_BITS;
         2:       return L2_BITS;
         default: return L3_BITS;
      endcase
   endfunction

   function automatic int lvl_lsb(int l);
      int s;
      s = VA_W;
      for (int k = 1; k <= l; k++) s = s - lvl_bits(k);
      return s;
   endfunction

   logic [PA_W-1:0] idx_off [0:MAX_LVL];

   // level 0 indexes the context table by context number
   assign idx_off[0] = PA_W'({ctx_i, 2'b00});

   for (genvar g = 1; g <= MAX_LVL; g++) begin : g_idx
      localparam int W = lvl_bits(g);
      localparam int L = lvl_lsb(g);
      assign idx_off[g] = PA_W'({va_i[L+W-1:L], 2'b00});
   end

   assign addr_o = base_i + idx_off[level_i];
endmodule

// File: rtl/tw_entry_decode.sv
module tw_entry_decode
   import tablewalk_pkg::*;
#(
   parameter int FAULT_W = 10
) (
   input  logic [ENT_W-1:0]   entry_i,
   input  logic [LVL_W-1:0]   level_i,
   input  logic               bus_err_i,
   output dec_kind_e          kind_o,
   output logic [FAULT_W-1:0] fault_o
);
   ent_kind_e  ek;
   logic [2:0] ftype;

   assign ek = ent_kind_e'(entry_i[1:0]);

   always_comb begin
      kind_o = DC_FAULT;
      ftype  = FT_XLATE;
      if (!bus_err_i) begin
         unique case (ek)
            EK_INVALID: ftype = FT_INVALID;
            EK_RSVD:    ftype = FT_XLATE;
            EK_TABLE: begin
               if (level_i != LVL_W'(MAX_LVL)) kind_o = DC_DESCEND;
            end
            EK_LEAF: begin
               if (level_i != '0) kind_o = DC_LEAF;
            end
         endcase
      end
   end

   assign fault_o = (kind_o == DC_FAULT)
                  ? ((FAULT_W'(level_i) << 8) | (FAULT_W'(ftype) << 2))
                  : '0;
endmodule

// File: rtl/tw_leaf_calc.sv
module tw_leaf_calc
   import tablewalk_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 36,
   parameter int L1_BITS = 8,
   parameter int L2_BITS = 6,
   parameter int L3_BITS = 6
) (
   input  logic [ENT_W-1:0] entry_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [VA_W-1:0]  va_i,
   input  logic             wr_i,
   output logic [PA_W-1:0]  pa_o,
   output pg_size_e         size_o,
   output logic             need_wb_o,
   output logic [ENT_W-1:0] upd_o
);
   localparam int OFF_BITS = VA_W - L1_BITS - L2_BITS - L3_BITS;
   localparam int FR_W     = PA_W - OFF_BITS;
   localparam int SPAN_W   = L2_BITS + L3_BITS;

   logic [SPAN_W-1:0] span;
   logic [SPAN_W-1:0] off_pages;
   logic [FR_W-1:0]   frame;

   assign span = va_i[VA_W-L1_BITS-1:OFF_BITS];

   always_comb begin
      unique case (level_i)
         2'd1: begin
            off_pages = span;
            size_o    = PS_16M;
         end
         2'd2: begin
            off_pages = SPAN_W'(span[L3_BITS-1:0]);
            size_o    = PS_256K;
         end
         2'd3: begin
            off_pages = '0;
            size_o    = PS_4K;
         end
         default: begin
            off_pages = '0;
            size_o    = PS_NONE;
         end
      endcase
   end

   assign frame = FR_W'(entry_i[ENT_W-1:PPN_LSB]) + FR_W'(off_pages);
   assign pa_o  = {frame, va_i[OFF_BITS-1:0]};

   assign need_wb_o = !entry_i[REF_BIT] || (wr_i && !entry_i[MOD_BIT]);

   always_comb begin
      upd_o          = entry_i;
      upd_o[REF_BIT] = 1'b1;
      if (wr_i) upd_o[MOD_BIT] = 1'b1;
   end
endmodule

// File: rtl/tablewalk_unit.sv
module tablewalk_unit
   import tablewalk_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 36,
   parameter int CTP_W   = 32,
   parameter int CTX_W   = 8,
   parameter int L1_BITS = 8,
   parameter int L2_BITS = 6,
   parameter int L3_BITS = 6,
   parameter int FAULT_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [VA_W-1:0]    va_i,
   input  logic               wr_i,
   input  logic [CTP_W-1:0]   ctp_i,
   input  logic [CTX_W-1:0]   ctx_i,
   output logic               mem_req_valid_o,
   input  logic               mem_req_ready_i,
   output logic [PA_W-1:0]    mem_req_addr_o,
   output logic               mem_req_we_o,
   output logic [31:0]        mem_req_wdata_o,
   input  logic               mem_rsp_valid_i,
   input  logic [31:0]        mem_rsp_data_i,
   input  logic               mem_rsp_err_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [PA_W-1:0]    pa_o,
   output logic [31:0]        leaf_o,
   output logic [1:0]         page_size_o,
   output logic [FAULT_W-1:0] fault_o
);
   localparam int OFF_BITS = VA_W - L1_BITS - L2_BITS - L3_BITS;

   // elaboration-time parameter checks
   if (OFF_BITS < 1) begin : g_bad_split
      $error("level index widths exceed the virtual address width");
   end
   if (PA_W - OFF_BITS != ENT_W - PPN_LSB) begin : g_bad_pa
      $error("physical width does not match the entry frame field");
   end
   if (CTP_W + 4 > PA_W) begin : g_bad_ctp
      $error("context table pointer too wide for the physical address");
   end
   if (CTX_W + 2 > PA_W) begin : g_bad_ctx
      $error("context number too wide");
   end
   if (FAULT_W < 10) begin : g_bad_fault
      $error("fault code needs at least 10 bits");
   end

   walk_st_e          st_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [PA_W-1:0]   base_q;
   logic [VA_W-1:0]   va_q;
   logic              wr_q;
   logic [CTX_W-1:0]  ctx_q;
   logic              done_q;
   logic [PA_W-1:0]   pa_q;
   logic [ENT_W-1:0]  leaf_q;
   pg_size_e          ps_q;
   logic [FAULT_W-1:0] fault_q;

   logic [PA_W-1:0]   fetch_addr;
   dec_kind_e         dec_kind;
   logic [FAULT_W-1:0] dec_fault;
   logic [PA_W-1:0]   lc_pa;
   pg_size_e          lc_size;
   logic              lc_need_wb;
   logic [ENT_W-1:0]  lc_upd;

   tw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W),
      .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS)
   ) u_addr (
      .level_i (lvl_q),
      .base_i  (base_q),
      .ctx_i   (ctx_q),
      .va_i    (va_q),
      .addr_o  (fetch_addr)
   );

   tw_entry_decode #(.FAULT_W(FAULT_W)) u_dec (
      .entry_i   (mem_rsp_data_i),
      .level_i   (lvl_q),
      .bus_err_i (mem_rsp_err_i),
      .kind_o    (dec_kind),
      .fault_o   (dec_fault)
   );

   tw_leaf_calc #(
      .VA_W(VA_W), .PA_W(PA_W),
      .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS)
   ) u_leaf (
      .entry_i   (mem_rsp_data_i),
      .level_i   (lvl_q),
      .va_i      (va_q),
      .wr_i      (wr_q),
      .pa_o      (lc_pa),
      .size_o    (lc_size),
      .need_wb_o (lc_need_wb),
      .upd_o     (lc_upd)
   );

   logic rsp_take;
   logic req_take;
   assign rsp_take = (st_q == ST_WAIT) && mem_rsp_valid_i;
   assign req_take = mem_req_valid_o && mem_req_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         lvl_q   <= '0;
         base_q  <= '0;
         va_q    <= '0;
         wr_q    <= 1'b0;
         ctx_q   <= '0;
         done_q  <= 1'b0;
         pa_q    <= '0;
         leaf_q  <= '0;
         ps_q    <= PS_NONE;
         fault_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_FETCH;
                  lvl_q  <= '0;
                  base_q <= PA_W'(ctp_i) << 4;
                  va_q   <= va_i;
                  wr_q   <= wr_i;
                  ctx_q  <= ctx_i;
               end
            end
            ST_FETCH: begin
               if (req_take) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_take) begin
                  unique case (dec_kind)
                     DC_DESCEND: begin
                        base_q <= PA_W'({mem_rsp_data_i[ENT_W-1:2], 2'b00}) << 4;
                        lvl_q  <= lvl_q + 1'b1;
                        st_q   <= ST_FETCH;
                     end
                     DC_LEAF: begin
                        pa_q    <= lc_pa;
                        leaf_q  <= lc_upd;
                        ps_q    <= lc_size;
                        fault_q <= '0;
                        if (lc_need_wb) begin
                           st_q <= ST_WBACK;
                        end else begin
                           st_q   <= ST_IDLE;
                           done_q <= 1'b1;
                        end
                     end
                     default: begin
                        pa_q    <= '0;
                        leaf_q  <= '0;
                        ps_q    <= PS_NONE;
                        fault_q <= dec_fault;
                        st_q    <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  endcase
               end
            end
            ST_WBACK: begin
               if (req_take) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
         endcase
      end
   end

   assign mem_req_valid_o = (st_q == ST_FETCH) || (st_q == ST_WBACK);
   assign mem_req_we_o    = (st_q == ST_WBACK);
   assign mem_req_addr_o  = fetch_addr;
   assign mem_req_wdata_o = leaf_q;
   assign busy_o          = (st_q != ST_IDLE);
   assign done_o          = done_q;
   assign pa_o            = pa_q;
   assign leaf_o          = leaf_q;
   assign page_size_o     = ps_q;
   assign fault_o         = fault_q;
endmodule

// File: rtl/tablewalk_chk.sv
module tablewalk_chk #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 36,
   parameter int CTP_W   = 32,
   parameter int CTX_W   = 8,
   parameter int FAULT_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [CTP_W-1:0]   ctp_i,
   input logic [CTX_W-1:0]   ctx_i,
   input logic               mem_req_valid_o,
   input logic               mem_req_ready_i,
   input logic [PA_W-1:0]    mem_req_addr_o,
   input logic               mem_req_we_o,
   input logic [31:0]        mem_req_wdata_o,
   input logic               busy_o,
   input logic               done_o,
   input logic [PA_W-1:0]    pa_o,
   input logic [31:0]        leaf_o,
   input logic [1:0]         page_size_o,
   input logic [FAULT_W-1:0] fault_o
);
   assert_first_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (mem_req_valid_o && !mem_req_we_o &&
         mem_req_addr_o == ((PA_W'($past(ctp_i)) << 4) + PA_W'({$past(ctx_i), 2'b00}))));

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && !mem_req_ready_i) |=>
         (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
          && $stable(mem_req_wdata_o)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_fault_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != '0) |-> (pa_o == '0 && leaf_o == '0 && page_size_o == 2'd0));

   assert_leaf_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o == '0) |-> (page_size_o != 2'd0));

   assert_fault_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != '0) |->
         ((fault_o[4:2] == 3'd1 || fault_o[4:2] == 3'd4) && fault_o[1:0] == 2'b00
          && fault_o[7:5] == 3'b000));

   assert_wb_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && mem_req_we_o) |-> mem_req_wdata_o[5]);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_valid_o);
endmodule

bind tablewalk_unit tablewalk_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .CTP_W(CTP_W), .CTX_W(CTX_W), .FAULT_W(FAULT_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .ctp_i           (ctp_i),
   .ctx_i           (ctx_i),
   .mem_req_valid_o (mem_req_valid_o),
   .mem_req_ready_i (mem_req_ready_i),
   .mem_req_addr_o  (mem_req_addr_o),
   .mem_req_we_o    (mem_req_we_o),
   .mem_req_wdata_o (mem_req_wdata_o),
   .busy_o          (busy_o),
   .done_o          (done_o),
   .pa_o            (pa_o),
   .leaf_o          (leaf_o),
   .page_size_o     (page_size_o),
   .fault_o         (fault_o)
);

// File: tb/tablewalk_unit_tb.sv
module tablewalk_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PA_W = 36;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] va_i = '0;
   logic        wr_i = 1'b0;
   logic [31:0] ctp_i = 32'h10;
   logic [7:0]  ctx_i = 8'd2;
   logic        mem_req_valid_o;
   logic        mem_req_ready_i = 1'b0;
   logic [PA_W-1:0] mem_req_addr_o;
   logic        mem_req_we_o;
   logic [31:0] mem_req_wdata_o;
   logic        mem_rsp_valid_i = 1'b0;
   logic [31:0] mem_rsp_data_i = '0;
   logic        mem_rsp_err_i = 1'b0;
   logic        busy_o, done_o;
   logic [PA_W-1:0] pa_o;
   logic [31:0] leaf_o;
   logic [1:0]  page_size_o;
   logic [9:0]  fault_o;

   tablewalk_unit u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;

   // memory model state
   logic [31:0]     mem [0:1023];
   logic [PA_W-1:0] err_addr = '1;
   int              stall_cnt = 0;
   logic [PA_W-1:0] trace [0:7];
   int              tr_n = 0;
   int              wb_n = 0;
   logic [PA_W-1:0] wb_addr = '0;
   logic [31:0]     wb_data = '0;
   int              done_cnt = 0;

   // captured results
   logic [PA_W-1:0] r_pa;
   logic [31:0]     r_leaf;
   logic [1:0]      r_ps;
   logic [9:0]      r_fault;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // responder: acts at negedges, its outputs are sampled at the next posedge
   initial begin : responder
      bit          pending = 0;
      int          delay = 0;
      logic [PA_W-1:0] paddr = '0;
      forever begin
         @(negedge clk);
         if (done_o) done_cnt++;
         mem_rsp_valid_i = 1'b0;
         mem_rsp_err_i   = 1'b0;
         if (pending) begin
            if (delay == 0) begin
               mem_rsp_valid_i = 1'b1;
               if (paddr[PA_W-1:12] != '0 || paddr == err_addr) begin
                  mem_rsp_err_i  = 1'b1;
                  mem_rsp_data_i = 32'hDEAD_BEEF;
               end else begin
                  mem_rsp_data_i = mem[paddr[11:2]];
               end
               pending = 0;
            end else begin
               delay--;
            end
         end
         mem_req_ready_i = (stall_cnt == 0);
         if (stall_cnt > 0) stall_cnt--;
         if (mem_req_valid_o && mem_req_ready_i) begin
            if (mem_req_we_o) begin
               wb_n++;
               wb_addr = mem_req_addr_o;
               wb_data = mem_req_wdata_o;
               mem[mem_req_addr_o[11:2]] = mem_req_wdata_o;
            end else begin
               if (tr_n < 8) trace[tr_n] = mem_req_addr_o;
               tr_n++;
               paddr   = mem_req_addr_o;
               pending = 1;
               delay   = 1;
            end
         end
      end
   end

   // default tables: VA 0x03147ABC walks 0x108 -> 0x40C -> 0x814 -> 0xC1C
   task automatic init_tables();
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      mem[32'h108 >> 2] = 32'h0000_0041;
      mem[32'h40C >> 2] = 32'h0000_0081;
      mem[32'h814 >> 2] = 32'h0000_00C1;
      mem[32'hC1C >> 2] = 32'h0123_4562;
      err_addr = '1;
      tr_n = 0;
      wb_n = 0;
   endtask

   task automatic walk(input logic [31:0] va, input logic wr, input string tag);
      int n;
      @(negedge clk);
      start_i = 1'b1; va_i = va; wr_i = wr;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(done_o, {tag, " done seen"}, done_o, 1);
      r_pa = pa_o; r_leaf = leaf_o; r_ps = page_size_o; r_fault = fault_o;
   endtask

   localparam logic [31:0] VA0 = 32'h0314_7ABC;

   task automatic t_reset();
      chk(!busy_o && !mem_req_valid_o && !done_o, "R11 reset idle",
          {busy_o, mem_req_valid_o, done_o}, 0);
   endtask

   task automatic t_full_walk();
      init_tables();
      walk(VA0, 1'b0, "R3 4K");
      chk(tr_n == 4, "R2 read count", tr_n, 4);
      chk(trace[0] == 36'h108, "R1 first addr", trace[0], 36'h108);
      chk(trace[1] == 36'h40C, "R2 level1 addr", trace[1], 36'h40C);
      chk(trace[2] == 36'h814, "R2 level2 addr", trace[2], 36'h814);
      chk(trace[3] == 36'hC1C, "R2 level3 addr", trace[3], 36'hC1C);
      chk(r_pa == 36'h012345ABC, "R3 4K pa", r_pa, 36'h012345ABC);
      chk(r_ps == 2'd1 && r_fault == 0, "R3 4K size", {r_ps, r_fault}, {2'd1, 10'd0});
      chk(r_leaf == 32'h0123_4562, "R3 leaf", r_leaf, 32'h0123_4562);
      chk(wb_n == 0, "R7 no write", wb_n, 0);
      @(negedge clk);
      chk(!done_o, "R9 pulse one cycle", done_o, 0);
      chk(pa_o == 36'h012345ABC, "R9 result held", pa_o, 36'h012345ABC);
   endtask

   task automatic t_large_pages();
      init_tables();
      mem[32'h40C >> 2] = 32'h1000_0062;
      walk(VA0, 1'b0, "R3 16M");
      chk(r_pa == 36'h100147ABC && r_ps == 2'd3, "R3 16M pa/size", r_pa, 36'h100147ABC);
      chk(tr_n == 2, "R3 16M stops early", tr_n, 2);
      init_tables();
      mem[32'h814 >> 2] = 32'h2000_0062;
      walk(VA0, 1'b0, "R3 256K");
      chk(r_pa == 36'h200007ABC && r_ps == 2'd2, "R3 256K pa/size", r_pa, 36'h200007ABC);
   endtask

   task automatic t_invalid();
      init_tables();
      mem[32'h814 >> 2] = 32'h0;
      walk(VA0, 1'b0, "R4 L2");
      chk(r_fault == 10'h204, "R4 invalid level2", r_fault, 10'h204);
      chk(r_pa == 0 && r_ps == 0 && r_leaf == 0, "R9 fault zeroes", r_pa, 0);
      init_tables();
      mem[32'h108 >> 2] = 32'h0;
      walk(VA0, 1'b0, "R4 L0");
      chk(r_fault == 10'h004, "R4 invalid context", r_fault, 10'h004);
   endtask

   task automatic t_xlate_err();
      init_tables();
      mem[32'h40C >> 2] = 32'h3;
      walk(VA0, 1'b0, "R5 rsvd");
      chk(r_fault == 10'h110, "R5 reserved level1", r_fault, 10'h110);
      init_tables();
      mem[32'hC1C >> 2] = 32'h0000_0041;
      walk(VA0, 1'b0, "R5 ptr3");
      chk(r_fault == 10'h310, "R5 table at level3", r_fault, 10'h310);
      init_tables();
      mem[32'h108 >> 2] = 32'h0123_4562;
      walk(VA0, 1'b0, "R5 ctxleaf");
      chk(r_fault == 10'h010, "R5 leaf in context", r_fault, 10'h010);
      init_tables();
      err_addr = 36'h814;
      walk(VA0, 1'b0, "R5 buserr");
      chk(r_fault == 10'h210, "R5 bus error level2", r_fault, 10'h210);
   endtask

   task automatic t_writeback();
      init_tables();
      mem[32'hC1C >> 2] = 32'h0123_4502;
      walk(VA0, 1'b0, "R6 read");
      chk(wb_n == 1 && wb_addr == 36'hC1C, "R6 wb addr", wb_addr, 36'hC1C);
      chk(wb_data == 32'h0123_4522, "R6 wb ref set", wb_data, 32'h0123_4522);
      chk(r_leaf == 32'h0123_4522, "R6 leaf updated", r_leaf, 32'h0123_4522);
      init_tables();
      mem[32'hC1C >> 2] = 32'h0123_4522;
      walk(VA0, 1'b1, "R6 write");
      chk(wb_n == 1 && wb_data == 32'h0123_4562, "R6 wb mod set", wb_data, 32'h0123_4562);
      chk(mem[32'hC1C >> 2] == 32'h0123_4562, "R6 memory updated", mem[32'hC1C >> 2], 32'h0123_4562);
      init_tables();
      mem[32'hC1C >> 2] = 32'h0123_4522;
      walk(VA0, 1'b0, "R7 read clean");
      chk(wb_n == 0, "R7 read with mod clear", wb_n, 0);
      init_tables();
      walk(VA0, 1'b1, "R7 write dirty");
      chk(wb_n == 0, "R7 write already modified", wb_n, 0);
   endtask

   task automatic t_busy_start();
      int d0;
      int n;
      init_tables();
      d0 = done_cnt;
      @(negedge clk);
      start_i = 1'b1; va_i = VA0; wr_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      start_i = 1'b1; va_i = 32'h0; wr_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(pa_o == 36'h012345ABC, "R8 first walk result", pa_o, 36'h012345ABC);
      repeat (20) @(negedge clk);
      chk(done_cnt - d0 == 1, "R8 single completion", done_cnt - d0, 1);
      chk(tr_n == 4 && wb_n == 0, "R8 no extra traffic", tr_n, 4);
      chk(!busy_o, "R8 idle after", busy_o, 0);
   endtask

   task automatic t_stall();
      init_tables();
      stall_cnt = 5;
      walk(VA0, 1'b0, "R10 stall");
      chk(r_pa == 36'h012345ABC && tr_n == 4, "R10 stalled walk result", r_pa, 36'h012345ABC);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      init_tables();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_walk();
      t_large_pages();
      t_invalid();
      t_xlate_err();
      t_writeback();
      t_busy_start();
      t_stall();
      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule